// File: doc/BRIEF.md
# Chainable serial register port

This block is a serial-peripheral slave that gives byte-wide read and write access to a small bank of control registers. Chip select is active low. The serial clock and data input are sampled by the block's own system clock, and their edges are detected inside the block. Input data is taken on each rising serial clock edge. Read data moves on each falling edge. The output data line is modelled as a value plus a drive enable.

Each transfer is a control byte followed by a data byte, both sent MSB first. When chaining is switched on, a select byte comes before them. The port takes its own select from that byte's least significant bit. It passes a one-bit-delayed copy of the byte to the next port. That copy equals the byte shifted right by one bit with a zero shifted in at the top. The control and data bytes then pass straight through. Ports can be strung together this way on one shared chip select and serial clock, and each one claims the next bit of the select byte.

Top module: `spi_chain_port`

## Requirements
- R1: After reset every register reads 0, chaining is off and the data output is not driven; whenever chip select is high the drive enable is low.
- R2: While chip select is high, serial clock and data input activity changes no register and does not drive the output.
- R3: A frame without chaining is a control byte and then a data byte, MSB first. Control bit 7 is 1 for read and 0 for write, and bits 6:0 hold the register address. A write takes effect when the last data bit is received.
- R4: On a read, the register value is shifted out MSB first during the data byte. Each bit is presented on a falling serial clock edge, starting with the falling edge right after the last control bit, so it is stable at the next rising edge.
- R5: Addresses at or above the bank size are not backed: writes to them change nothing and reads from them return 0.
- R6: Register 0 bit 7 enables chaining and register 0 bit 6 selects early release. Both read back as written.
- R7: With chaining on, the first byte of a frame is the select byte. Its bit 0 decides whether this port carries out the access.
- R8: With chaining on, during the select byte the pass-through output equals the data input delayed by one serial clock. Seen at the rising edges, it is the select byte shifted right by one with 0 in bit 7.
- R9: After the select byte, and at all times without chaining, the pass-through output equals the data input unaltered.
- R10: A port whose select bit is 0 still forwards the stream, but it writes no register and never drives the output.
- R11: With early release off, the output stays driven after the last read bit until chip select rises.
- R12: With early release on, the output drive is released at the rising serial clock edge of the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Drive enable for sdo_o; low means high impedance |
| thru_o | output | 1 | Pass-through data to the next port in a chain |

## Verification
The assertions assume that the serial clock and data input are already synchronous to the system clock. They also assume that each serial clock level lasts several system clocks, that data input only changes while the serial clock is low, and that chip select only changes while the serial clock is low. The bench drives every input at the falling system clock edge and holds each serial clock phase for four system cycles. It changes chip select only between whole bytes. In this way no rising and falling serial edge is ever seen in the same cycle. A second port is fed from the first port's pass-through output, so the chain is checked end to end.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  typedef enum logic [1:0] {
    PH_SEL  = 2'd0,
    PH_CTRL = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_chain_edge.sv
module spi_chain_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = !cs_ni &&  sclk_i && !sclk_q;
  assign fall_o = !cs_ni && !sclk_i &&  sclk_q;
endmodule

// File: rtl/spi_chain_regs.sv
module spi_chain_regs #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-2:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          chain_o,
  output logic          early_o
);
  localparam int unsigned AW = DW - 1;
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[g] <= '0;
      else if (we_i && addr_i == AW'(g))    regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (addr_i < AW'(NREG)) ? regs_q[addr_i[IW-1:0]] : '0;
  assign chain_o = regs_q[0][DW-1];
  assign early_o = regs_q[0][DW-2];
endmodule

// File: rtl/spi_chain_frame.sv
module spi_chain_frame
  import spi_chain_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sdi_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          chain_i,
  input  logic          early_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-2:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          thru_o
);
  localparam int unsigned CW = $clog2(3 * DW + 1);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic          sel_q, thru_q, rw_q, act_q, sdo_q, oe_q;
  logic [DW-1:0] in_sr_q, out_sr_q;
  logic [DW-2:0] addr_q;
  logic [CW-1:0] ctrl_base, data_base;
  logic [DW-1:0] byte_now;
  logic          sel_eff, last_bit;
  phase_e        phase;

  assign ctrl_base = chain_i ? CW'(DW) : '0;
  assign data_base = ctrl_base + CW'(DW);
  assign byte_now  = {in_sr_q[DW-2:0], sdi_i};
  assign sel_eff   = chain_i ? sel_q : 1'b1;

  always_comb begin
    if (chain_i && cnt_q < CW'(DW)) begin
      phase    = PH_SEL;
      last_bit = (cnt_q == CW'(DW - 1));
    end else if (cnt_q < data_base) begin
      phase    = PH_CTRL;
      last_bit = (cnt_q == ctrl_base + CW'(DW - 1));
    end else if (cnt_q < data_base + CW'(DW)) begin
      phase    = PH_DATA;
      last_bit = (cnt_q == data_base + CW'(DW - 1));
    end else begin
      phase    = PH_DONE;
      last_bit = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; sel_q <= 1'b0; thru_q <= 1'b0; rw_q <= 1'b0;
      act_q <= 1'b0; sdo_q <= 1'b0; oe_q <= 1'b0;
      in_sr_q <= '0; out_sr_q <= '0; addr_q <= '0;
    end else if (cs_ni) begin
      cnt_q <= '0; sel_q <= 1'b0; thru_q <= 1'b0;
      act_q <= 1'b0; sdo_q <= 1'b0; oe_q <= 1'b0;
      in_sr_q <= '0;
    end else begin
      if (rise_i) begin
        in_sr_q <= byte_now;
        thru_q  <= sdi_i;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (last_bit) begin
          unique case (phase)
            PH_SEL:  sel_q <= sdi_i;
            PH_CTRL: begin
              rw_q     <= byte_now[DW-1];
              addr_q   <= byte_now[DW-2:0];
              act_q    <= sel_eff && byte_now[DW-1];
              out_sr_q <= rdata_i;
            end
            PH_DATA: begin
              act_q <= 1'b0;
              if (early_i) oe_q <= 1'b0;
            end
            default: ;
          endcase
        end
      end
      if (fall_i && act_q && phase == PH_DATA) begin
        sdo_q    <= out_sr_q[DW-1];
        out_sr_q <= {out_sr_q[DW-2:0], 1'b0};
        oe_q     <= 1'b1;
      end
    end
  end

  // read address must be valid in the cycle the control byte completes
  assign addr_o   = (phase == PH_CTRL) ? byte_now[DW-2:0] : addr_q;
  assign we_o     = rise_i && phase == PH_DATA && last_bit && sel_eff && !rw_q;
  assign wdata_o  = byte_now;
  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
  assign thru_o   = (chain_i && phase == PH_SEL) ? thru_q : sdi_i;

  a_r1_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !sdo_oe_o);

  a_r4_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !fall_i) |=> $stable(sdo_o));

  a_r8_thru_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && chain_i && cnt_q < CW'(DW - 1)) |=> (cs_ni || thru_o == $past(sdi_i)));

  a_r10_unsel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_i && phase != PH_SEL && !sel_q) |-> !sdo_oe_o);

  a_r12_early_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && early_i && phase == PH_DATA && last_bit) |=> !sdo_oe_o);
endmodule

// File: rtl/spi_chain_port.sv
module spi_chain_port #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic thru_o
);
  logic          rise, fall, we, chain, early;
  logic [DW-2:0] addr;
  logic [DW-1:0] wdata, rdata;

  spi_chain_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_chain_frame #(.DW(DW)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .sdi_i    (sdi_i),
    .rise_i   (rise),
    .fall_i   (fall),
    .chain_i  (chain),
    .early_i  (early),
    .rdata_i  (rdata),
    .addr_o   (addr),
    .we_o     (we),
    .wdata_o  (wdata),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .thru_o   (thru_o)
  );

  spi_chain_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .chain_o (chain),
    .early_o (early)
  );
endmodule

// File: tb/tb_spi_chain_port.sv
module tb_spi_chain_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo_a, oe_a, thru_a, sdo_b, oe_b, thru_b;
  int n_chk = 0, n_fail = 0;
  logic [7:0] ma [4];
  logic [7:0] mb [4];

  always #2 clk = ~clk;

  spi_chain_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo_a), .sdo_oe_o(oe_a), .thru_o(thru_a));

  spi_chain_port dut_b (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(thru_a),
    .sdo_o(sdo_b), .sdo_oe_o(oe_b), .thru_o(thru_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx_a,
                       output logic [7:0] rx_b, output logic [7:0] th);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sdi = tx[i]; sclk = 1'b0;
      repeat (3) @(negedge clk);
      rx_a[i] = sdo_a; rx_b[i] = sdo_b; th[i] = thru_a;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input bit chained, input logic [7:0] selb, input logic [7:0] ctrl,
                       input logic [7:0] data, output logic [7:0] rx_a, output logic [7:0] rx_b,
                       output logic [7:0] th_sel, output logic [7:0] th_ctl,
                       output logic [7:0] th_dat, output logic oe_a_end, output logic oe_b_end);
    logic [7:0] d0, d1;
    th_sel = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    if (chained) xbyte(selb, d0, d1, th_sel);
    xbyte(ctrl, d0, d1, th_ctl);
    xbyte(data, rx_a, rx_b, th_dat);
    repeat (2) @(negedge clk);
    oe_a_end = oe_a; oe_b_end = oe_b;
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ra, rb, ts, tc, td, dat;
    logic ea, eb;
    bit oe_seen;
    for (int k = 0; k < 4; k++) begin ma[k] = '0; mb[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk("R1 oe_a after reset", oe_a, 0);
    chk("R1 oe_b after reset", oe_b, 0);
    for (int a = 0; a < 4; a++) begin
      frame(0, 8'h00, {1'b1, 7'(a)}, 8'h00, ra, rb, ts, tc, td, ea, eb);
      chk("R1 reset value a", ra, 0);
      chk("R1 reset value b", rb, 0);
      chk("R1 released after cs high", oe_a, 0);
    end

    // R3 R4 R9 R11: single mode write and readback sweep
    for (int p = 0; p < 3; p++) begin
      for (int a = 1; a < 4; a++) begin
        dat = 8'((a * 8'h35) ^ (p * 8'h5A) ^ 8'h11);
        frame(0, 8'h00, {1'b0, 7'(a)}, dat, ra, rb, ts, tc, td, ea, eb);
        ma[a] = dat; mb[a] = dat;
        chk("R9 single ctrl forwarded", tc, {1'b0, 7'(a)});
        chk("R9 single data forwarded", td, dat);
        chk("R3 write leaves bus undriven", ea, 0);
      end
      for (int a = 1; a < 4; a++) begin
        frame(0, 8'h00, {1'b1, 7'(a)}, 8'h00, ra, rb, ts, tc, td, ea, eb);
        chk("R4 read data a", ra, ma[a]);
        chk("R4 read data b", rb, mb[a]);
        chk("R11 late release holds drive", ea, 1);
        chk("R11 released after cs high", oe_a, 0);
      end
    end

    // R5: unbacked addresses
    frame(0, 8'h00, {1'b0, 7'd5}, 8'hFF, ra, rb, ts, tc, td, ea, eb);
    frame(0, 8'h00, {1'b0, 7'h7F}, 8'hA5, ra, rb, ts, tc, td, ea, eb);
    frame(0, 8'h00, {1'b1, 7'd5}, 8'h00, ra, rb, ts, tc, td, ea, eb);
    chk("R5 unbacked read zero", ra, 0);
    for (int a = 0; a < 4; a++) begin
      frame(0, 8'h00, {1'b1, 7'(a)}, 8'h00, ra, rb, ts, tc, td, ea, eb);
      chk("R5 bank untouched", ra, ma[a]);
    end

    // R2: activity with cs high
    oe_seen = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); sdi = i[0] ^ i[2]; sclk = 1'b1;
      repeat (3) @(negedge clk); if (oe_a || oe_b) oe_seen = 1;
      sclk = 1'b0;
      repeat (3) @(negedge clk); if (oe_a || oe_b) oe_seen = 1;
    end
    chk("R2 no drive with cs high", oe_seen, 0);
    for (int a = 1; a < 4; a++) begin
      frame(0, 8'h00, {1'b1, 7'(a)}, 8'h00, ra, rb, ts, tc, td, ea, eb);
      chk("R2 regs unchanged", ra, ma[a]);
    end

    // R6: enable chaining in both ports
    frame(0, 8'h00, {1'b0, 7'd0}, 8'h80, ra, rb, ts, tc, td, ea, eb);
    ma[0] = 8'h80; mb[0] = 8'h80;
    frame(1, 8'h03, {1'b1, 7'd0}, 8'h00, ra, rb, ts, tc, td, ea, eb);
    chk("R6 reg0 a", ra, 8'h80);
    chk("R6 reg0 b", rb, 8'h80);

    // R7 R8 R9 R10: select byte sweep
    for (int s = 0; s < 16; s++) begin
      logic [7:0] selb;
      selb = 8'(s[1:0]) | 8'((s >> 2) * 8'h44);
      dat  = 8'(8'hC3 ^ (s * 8'h17));
      frame(1, selb, {1'b0, 7'd2}, dat, ra, rb, ts, tc, td, ea, eb);
      if (selb[0]) ma[2] = dat;
      if (selb[1]) mb[2] = dat;
      chk("R8 select byte shifted", ts, {1'b0, selb[7:1]});
      chk("R9 ctrl forwarded", tc, {1'b0, 7'd2});
      chk("R9 data forwarded", td, dat);
      frame(1, 8'h01, {1'b1, 7'd2}, 8'h00, ra, rb, ts, tc, td, ea, eb);
      chk("R7 selected port a value", ra, ma[2]);
      chk("R10 unselected b not driving", eb, 0);
      frame(1, 8'h02, {1'b1, 7'd2}, 8'h00, ra, rb, ts, tc, td, ea, eb);
      chk("R7 selected port b value", rb, mb[2]);
      chk("R10 unselected a not driving", ea, 0);
    end

    // R12: early release
    frame(1, 8'h03, {1'b0, 7'd0}, 8'hC0, ra, rb, ts, tc, td, ea, eb);
    ma[0] = 8'hC0; mb[0] = 8'hC0;
    for (int a = 0; a < 4; a++) begin
      frame(1, 8'h01, {1'b1, 7'(a)}, 8'h00, ra, rb, ts, tc, td, ea, eb);
      chk("R12 data correct in early mode", ra, ma[a]);
      chk("R12 released at last bit", ea, 0);
    end
    frame(1, 8'h03, {1'b1, 7'd0}, 8'h00, ra, rb, ts, tc, td, ea, eb);
    chk("R6 reg0 early bit a", ra, 8'hC0);
    chk("R6 reg0 early bit b", rb, 8'hC0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule